// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Back End

This block is the digital tail of an 8-bit flash converter. It receives one bit per comparator: 255 ladder comparators form a thermometer that rises from the bottom, and one further comparator above them flags an input beyond the top reference. On every rising edge of the encode clock the block captures the whole vector. It removes isolated bubble errors with a three-way majority vote, counts the surviving ones to form a binary code, and reports overrange in one of two ways.

A static mode level, captured together with each sample, picks the overrange report. In return-to-zero mode, overrange raises the overflow flag and forces the code to zero. In saturating mode, overrange leaves the flag low and forces the code to all ones. Results come out of a second register, one full encode cycle after the edge that sampled them.

Top module: `flash_therm_decoder`

## Requirements
- R1: Bit i of `cmp_levels` for i = 0 to 254 is ladder comparator i+1, with bit 0 the lowest. Bit 255 is the overrange comparator. A 1 means the input lies above that threshold.
- R2: For an in-range sample, `code_out` equals the number of ones in the bubble-corrected ladder bits 0 to 254. An all-zero ladder gives 0 and an all-one ladder gives 255.
- R3: When bit 255 is 1 and `ovr_inhibit` is 0 (return-to-zero mode), `ovr_flag` is 1 and `code_out` is 0.
- R4: When bit 255 is 1 and `ovr_inhibit` is 1 (saturating mode), `ovr_flag` is 0 and `code_out` is 255.
- R5: When bit 255 is 0, `ovr_flag` is 0 in both modes and the code follows R2.
- R6: Inputs sampled at rising edge N appear on the outputs after rising edge N+1 and hold until edge N+2. Samples on consecutive edges are delivered on consecutive edges.
- R7: Each corrected ladder bit is the majority of the raw bit and its two neighbours. A lone 0 inside a run of ones, or a lone 1 above the run, is therefore removed, and a clean thermometer of k ones with one such bubble still gives code k.
- R8: At the ends of the ladder, the missing neighbour below bit 0 counts as 1 and the missing neighbour above bit 254 counts as 0. A ladder with only bit 1 set gives code 1. A ladder with only bit 254 set gives code 0.
- R9: `ovr_inhibit` is sampled on the same edge as `cmp_levels`. Changing the mode between two consecutive overrange samples changes only the second result.
- R10: While `rst_n` is low at a rising edge, both pipeline stages clear. The outputs read code 0 with flag 0 after that edge and also after the first edge following release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_levels | input | 256 | Comparator outputs: ladder bits 0..254 and the overrange bit 255 |
| ovr_inhibit | input | 1 | Overrange mode: 0 return-to-zero, 1 saturating |
| code_out | output | 8 | Binary conversion code, bit 7 most significant |
| ovr_flag | output | 1 | Overrange flag, high only in return-to-zero mode |

## Verification
On every cycle the checker holds the two overrange mappings, the low flag for in-range samples, and the zero result for an all-clear sample. It compares each output against the inputs captured two edges before, so it covers the latency and the per-sample mode capture. The bubble vote, the end-of-ladder rules, exact counts for arbitrary thermometers, and the clearing of both stages by reset can only be shown by the bench's directed scenarios. The bench's reference model supplies the expected code for each of those vectors.

// File: rtl/flash_dec_pkg.sv
// Package: types shared by the thermometer decoder and its checker.
// Assumes nothing beyond the encoding of the overrange mode level.
package flash_dec_pkg;

    // Overrange report style, as carried on the mode input
    typedef enum logic {
        OVR_RETURN_ZERO = 1'b0,
        OVR_SATURATE    = 1'b1
    } ovr_mode_e;

endpackage

// File: rtl/therm_bubble_vote.sv
// Module: therm_bubble_vote
// Replaces every thermometer bit with the majority of itself and its two
// neighbours. Assumes bit 0 is the lowest level; the virtual bit below the
// vector is 1 and the virtual bit above it is 0.
module therm_bubble_vote #(
    parameter int N_BITS = 255
) (
    input  logic [N_BITS-1:0] raw_therm,
    output logic [N_BITS-1:0] fixed_therm
);

    // Vector extended by the two fixed end neighbours
    logic [N_BITS+1:0] padded;

    assign padded = {1'b0, raw_therm, 1'b1};

    genvar g;
    generate
        for (g = 0; g < N_BITS; g++) begin : g_vote
            // Two-of-three vote over below, self, above
            assign fixed_therm[g] = (padded[g]   & padded[g+1])
                                  | (padded[g+1] & padded[g+2])
                                  | (padded[g]   & padded[g+2]);
        end
    endgenerate

endmodule

// File: rtl/therm_ones_count.sv
// Module: therm_ones_count
// Counts the ones in a corrected thermometer vector. Assumes the count of
// N_BITS ones fits in CNT_W bits.
module therm_ones_count #(
    parameter int N_BITS = 255,
    parameter int CNT_W  = 8
) (
    input  logic [N_BITS-1:0] therm,
    output logic [CNT_W-1:0]  count
);

    // Plain population count; the adder chain is left to synthesis to balance
    always_comb begin
        count = '0;
        for (int i = 0; i < N_BITS; i++) begin
            count = count + CNT_W'(therm[i]);
        end
    end

endmodule

// File: rtl/ovr_code_map.sv
// Module: ovr_code_map
// Selects the final code and flag from the ladder count, the overrange bit
// and the sampled mode. Assumes all inputs come from one sample.
module ovr_code_map
    import flash_dec_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] ladder_code,
    input  logic              over_top,
    input  ovr_mode_e         mode,
    output logic [CODE_W-1:0] code,
    output logic              flag
);

    // Overrange overrides the ladder code in the style the mode picks
    always_comb begin
        code = ladder_code;
        flag = 1'b0;
        if (over_top) begin
            if (mode == OVR_SATURATE) begin
                code = '1;
            end else begin
                code = '0;
                flag = 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_therm_decoder.sv
// Module: flash_therm_decoder
// Two-stage decoder for a flash converter: stage one captures comparator
// bits and mode on the encode edge; stage two registers the corrected,
// counted and mapped result. Assumes the ladder occupies bits 0..2^CODE_W-2
// and the overrange comparator is the top bit. Reset is synchronous, active low.
module flash_therm_decoder
    import flash_dec_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<CODE_W)-1:0] cmp_levels,
    input  logic                  ovr_inhibit,
    output logic [CODE_W-1:0]     code_out,
    output logic                  ovr_flag
);

    localparam int NUM_CMP = 1 << CODE_W;
    localparam int NUM_LVL = NUM_CMP - 1;

    logic [NUM_CMP-1:0] smp_levels;
    ovr_mode_e          smp_mode;
    logic [NUM_LVL-1:0] fixed_lvl;
    logic [CODE_W-1:0]  lvl_count;
    logic [CODE_W-1:0]  map_code;
    logic               map_flag;

    // Stage one: capture the comparator snapshot and its mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_levels <= '0;
            smp_mode   <= OVR_RETURN_ZERO;
        end else begin
            smp_levels <= cmp_levels;
            smp_mode   <= ovr_mode_e'(ovr_inhibit);
        end
    end

    therm_bubble_vote #(
        .N_BITS (NUM_LVL)
    ) u_vote (
        .raw_therm   (smp_levels[NUM_LVL-1:0]),
        .fixed_therm (fixed_lvl)
    );

    therm_ones_count #(
        .N_BITS (NUM_LVL),
        .CNT_W  (CODE_W)
    ) u_count (
        .therm (fixed_lvl),
        .count (lvl_count)
    );

    ovr_code_map #(
        .CODE_W (CODE_W)
    ) u_map (
        .ladder_code (lvl_count),
        .over_top    (smp_levels[NUM_CMP-1]),
        .mode        (smp_mode),
        .code        (map_code),
        .flag        (map_flag)
    );

    // Stage two: hold the decoded result for one encode period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= '0;
            ovr_flag <= 1'b0;
        end else begin
            code_out <= map_code;
            ovr_flag <= map_flag;
        end
    end

endmodule

// File: rtl/flash_therm_decoder_chk.sv
// Module: flash_therm_decoder_chk
// Cycle checks on the decoder ports. Relates each output to the inputs
// captured two edges earlier, once two edges have passed since reset.
module flash_therm_decoder_chk #(
    parameter int CODE_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [(1<<CODE_W)-1:0] cmp_levels,
    input logic                   ovr_inhibit,
    input logic [CODE_W-1:0]      code_out,
    input logic                   ovr_flag
);

    localparam int TOP = (1 << CODE_W) - 1;

    logic [1:0] live_cnt;

    // Count edges since reset release, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)              live_cnt <= 2'd0;
        else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
    end

    // R3: a raised flag always comes with a zero code
    p_flag_zero_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |-> (code_out == '0));

    // R3 / R6: return-to-zero overrange two edges ago raises the flag
    p_rtz_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd2 && $past(cmp_levels[TOP], 2) && !$past(ovr_inhibit, 2))
        |-> (ovr_flag && code_out == '0));

    // R4 / R9: saturating overrange gives all ones and no flag
    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd2 && $past(cmp_levels[TOP], 2) && $past(ovr_inhibit, 2))
        |-> (!ovr_flag && code_out == '1));

    // R5: no overrange, no flag
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd2 && !$past(cmp_levels[TOP], 2)) |-> !ovr_flag);

    // R2 / R6: an all-clear sample decodes to zero one cycle later
    p_all_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd2 && $past(cmp_levels, 2) == '0)
        |-> (code_out == '0 && !ovr_flag));

endmodule

bind flash_therm_decoder flash_therm_decoder_chk #(
    .CODE_W (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_levels  (cmp_levels),
    .ovr_inhibit (ovr_inhibit),
    .code_out    (code_out),
    .ovr_flag    (ovr_flag)
);

// File: tb/tb_flash_therm_decoder.sv
// Directed bench: each task drives one scenario through a streaming step
// that predicts results from the requirements and checks them two edges on.
module tb_flash_therm_decoder;

    localparam int CODE_W = 8;
    localparam int NC     = 1 << CODE_W;
    localparam int NL     = NC - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     cmp_levels = '0;
    logic              ovr_inhibit = 1'b0;
    logic [CODE_W-1:0] code_out;
    logic              ovr_flag;

    int n_chk  = 0;
    int n_fail = 0;

    logic [CODE_W:0] exp1, exp2;
    logic            val1 = 1'b0, val2 = 1'b0;
    string           tag1, tag2;

    always #4 clk = ~clk;

    flash_therm_decoder #(.CODE_W(CODE_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmp_levels(cmp_levels),
        .ovr_inhibit(ovr_inhibit), .code_out(code_out), .ovr_flag(ovr_flag)
    );

    // Expected {flag, code} from the requirements
    function automatic logic [CODE_W:0] model(input logic [NC-1:0] v, input logic inh);
        int cnt = 0;
        for (int i = 0; i < NL; i++) begin
            int below = (i == 0)      ? 1 : int'(v[i-1]);
            int above = (i == NL - 1) ? 0 : int'(v[i+1]);
            if (below + int'(v[i]) + above >= 2) cnt++;
        end
        if (v[NC-1]) return inh ? {1'b0, {CODE_W{1'b1}}} : {1'b1, {CODE_W{1'b0}}};
        return {1'b0, CODE_W'(cnt)};
    endfunction

    function automatic logic [NC-1:0] therm(input int k);
        logic [NC-1:0] v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic check_now(input logic [CODE_W:0] e, input string tag);
        n_chk++;
        if ({ovr_flag, code_out} !== e) begin
            n_fail++;
            $display("FAIL %s: got flag=%0b code=%0d, expected flag=%0b code=%0d",
                     tag, ovr_flag, code_out, e[CODE_W], e[CODE_W-1:0]);
        end
    endtask

    // One encode period: check the result due now, then drive a new sample
    task automatic step(input logic [NC-1:0] v, input logic inh, input string tag, input logic chk);
        @(negedge clk);
        if (val2) check_now(exp2, tag2);
        exp2 = exp1; val2 = val1; tag2 = tag1;
        exp1 = model(v, inh); val1 = chk; tag1 = tag;
        cmp_levels  = v;
        ovr_inhibit = inh;
    endtask

    task automatic flush();
        step('0, 1'b0, "", 1'b0);
        step('0, 1'b0, "", 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cmp_levels = therm(NC);
        ovr_inhibit = 1'b0;
        @(negedge clk);
        check_now('0, "R10 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now('0, "R10 first edge after release");
        val1 = 1'b0; val2 = 1'b0;
        flush();
    endtask

    task automatic t_ramp();
        for (int k = 0; k <= NL; k += 17) step(therm(k), k[0], "R1 R2 R5 clean ramp", 1'b1);
        step(therm(NL), 1'b0, "R2 full ladder", 1'b1);
        step(therm(NL), 1'b1, "R5 full ladder saturating mode", 1'b1);
        step('0, 1'b1, "R2 empty ladder", 1'b1);
        flush();
    endtask

    task automatic t_rtz();
        step(therm(NC), 1'b0, "R3 overrange all set", 1'b1);
        step(therm(40) | (NC'(1) << (NC-1)), 1'b0, "R3 overrange partial ladder", 1'b1);
        flush();
    endtask

    task automatic t_sat();
        step(therm(NC), 1'b1, "R4 overrange all set", 1'b1);
        step(NC'(1) << (NC-1), 1'b1, "R4 overrange empty ladder", 1'b1);
        flush();
    endtask

    task automatic t_latency();
        for (int k = 3; k < 30; k++) step(therm(k * 7), 1'b0, "R6 back-to-back samples", 1'b1);
        flush();
    endtask

    task automatic t_bubbles();
        logic [NC-1:0] v;
        v = therm(100); v[50] = 1'b0;
        step(v, 1'b0, "R7 lone zero inside run", 1'b1);
        v = therm(100); v[160] = 1'b1;
        step(v, 1'b0, "R7 lone one above run", 1'b1);
        v = therm(200); v[20] = 1'b0; v[230] = 1'b1;
        step(v, 1'b1, "R7 two separated bubbles", 1'b1);
        flush();
    endtask

    task automatic t_edges();
        step(NC'(2), 1'b0, "R8 only bit 1 set", 1'b1);
        step(NC'(1) << (NL-1), 1'b0, "R8 only bit 254 set", 1'b1);
        step(NC'(1), 1'b0, "R8 only bit 0 set", 1'b1);
        step(therm(NL - 1), 1'b0, "R8 all but top ladder bit", 1'b1);
        flush();
    endtask

    task automatic t_mode_switch();
        step(therm(NC), 1'b0, "R9 mode low then", 1'b1);
        step(therm(NC), 1'b1, "R9 mode high next", 1'b1);
        step(therm(NC), 1'b0, "R9 mode low again", 1'b1);
        flush();
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++) begin
            logic [NC-1:0] v;
            int k = $urandom_range(NL, 0);
            v = therm(k);
            if ($urandom_range(1, 0) == 1) begin
                int p = $urandom_range(NL - 1, 0);
                v[p] = ~v[p];
            end
            v[NC-1] = ($urandom_range(7, 0) == 0);
            step(v, 1'($urandom_range(1, 0)), "R2 R3 R4 R7 random mix", 1'b1);
        end
        flush();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_ramp();
        t_rtz();
        t_sat();
        t_latency();
        t_bubbles();
        t_edges();
        t_mode_switch();
        t_random();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule